// File: doc/BRIEF.md
# Protected Special Register Bank

A small bank of special-purpose registers that a processor reaches only through dedicated read and write operations, each naming a register by number. Whether that number comes from a register operand or an immediate field is settled by the decoder upstream. The bank only ever sees the number. Each register belongs to one of four classes:

- **Hardwired:** constants that describe the design.
- **Grant register:** one enable bit per supervisor register.
- **Supervisor registers:** these control shared resources.
- **User registers:** these carry no protection.

Every request is judged against the caller's privilege level, the grant bits and the constant writable-bit mask of the target register. A request is accepted in one cycle. The verdict comes one cycle later. The requester is held off by `stall` until that verdict arrives. A legal access then completes with a one-cycle `done` pulse. An illegal access raises a one-cycle `trap` with a cause code and leaves every register untouched. Unprivileged code may give up a grant but can never take one. A write mask that touches any bit the register does not implement is refused rather than silently trimmed, so those bits stay reserved.

Top module: `sreg_bank`

## Requirements
- R1: A read at any privilege level completes with `done` and returns the register value. Register 0 holds the REVISION parameter. Register 1 holds the geometry word: bits [7:0] give the implemented register count and bits [15:8] give DATA_W.
- R2: A write to register 0 or 1 traps with cause 2 (privilege) at every privilege level, and the hardwired value is unchanged afterwards.
- R3: Supervisor registers are numbered 3 to 3+NUM_SUP-1. A write with `priv`=1 is accepted. A write with `priv`=0 traps with cause 2, unless grant bit k of register 2 is set for supervisor register 3+k.
- R4: User registers follow the supervisor registers. A write to one is accepted at either privilege level.
- R5: Register 2 holds the grant bits in bits [NUM_SUP-1:0]. With `priv`=0, a write whose mask selects a bit together with a data value of 1 traps with cause 2, while a write that only clears bits is accepted. With `priv`=1 any write within the mask is accepted.
- R6: A write whose mask selects a bit outside the register's writable mask traps with cause 3 and changes nothing. The writable masks are SUP_WMASK for supervisor registers, USR_WMASK for user registers, the low NUM_SUP bits for register 2, and zero for hardwired registers.
- R7: An accepted write changes exactly the bits selected by the mask. Every other bit keeps its previous value.
- R8: A register number at or above the implemented count (3+NUM_SUP+NUM_USR) traps with cause 1, for both reads and writes, and `rdata` is zero.
- R9: When a request is accepted, `stall` is high in that cycle and in the following cycle. Exactly one of `done` or `trap` pulses, for one cycle, in the cycle after the request. A request raised while a verdict is pending is ignored.
- R10: When several faults apply, the cause with the highest priority is reported: range (1) first, then privilege (2), then mask (3). `cause` is 0 and `rdata` is 0 except during a trap, or during the done cycle of a read, respectively.
- R11: After reset, the grant, supervisor and user registers are zero, and `stall`, `done` and `trap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one cycle |
| wr | input | 1 | 1 = write, 0 = read |
| num | input | NUM_W | Register number |
| wdata | input | DATA_W | Write data |
| wmask | input | DATA_W | Bits the write intends to change |
| priv | input | 1 | 1 = supervisor level |
| rdata | output | DATA_W | Read result, valid with `done` of a read |
| stall | output | 1 | Requester must wait |
| done | output | 1 | Access completed |
| trap | output | 1 | Access refused |
| cause | output | 2 | Trap cause: 1 range, 2 privilege, 3 mask |

## Verification
The bench uses the default build: 32-bit registers, two supervisor and two user registers, and a 4-bit register number. This gives seven implemented registers, so numbers 7 to 15 exercise the range trap. The supervisor mask `0000FFFF` and the user mask `00FFFFFF` both leave upper bits unimplemented, which makes mask refusals reachable in both classes. With two grant bits, the bench can grant one supervisor register while the other stays locked, and so tell the per-resource grant apart from a global one.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   typedef enum logic [1:0] {
      CLS_HW    = 2'd0,
      CLS_GRANT = 2'd1,
      CLS_SUP   = 2'd2,
      CLS_USR   = 2'd3
   } sreg_cls_e;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'd0,
      CAUSE_RANGE = 2'd1,
      CAUSE_PRIV  = 2'd2,
      CAUSE_MASK  = 2'd3
   } sreg_cause_e;

   localparam int unsigned NUM_HW    = 2;
   localparam int unsigned GRANT_NUM = 2;
   localparam int unsigned FIRST_SUP = 3;
endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
   import sreg_pkg::*;
#(
   parameter int unsigned NUM_W     = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_SUP   = 2,
   parameter int unsigned NUM_USR   = 2,
   parameter logic [DATA_W-1:0] SUP_WMASK = '1,
   parameter logic [DATA_W-1:0] USR_WMASK = '1
) (
   input  logic [NUM_W-1:0]  num,
   output logic              in_range,
   output sreg_cls_e         cls,
   output logic [NUM_W-1:0]  idx,
   output logic [DATA_W-1:0] wr_mask
);
   localparam int unsigned NUM_REGS = FIRST_SUP + NUM_SUP + NUM_USR;
   localparam logic [NUM_W-1:0] L_HW_END  = NUM_W'(NUM_HW);
   localparam logic [NUM_W-1:0] L_GRANT   = NUM_W'(GRANT_NUM);
   localparam logic [NUM_W-1:0] L_SUP_BEG = NUM_W'(FIRST_SUP);
   localparam logic [NUM_W-1:0] L_SUP_END = NUM_W'(FIRST_SUP + NUM_SUP);
   localparam logic [NUM_W-1:0] L_END     = NUM_W'(NUM_REGS);
   localparam logic [DATA_W-1:0] GRANT_MASK = {{(DATA_W-NUM_SUP){1'b0}}, {NUM_SUP{1'b1}}};

   always_comb begin
      in_range = 1'b1;
      cls      = CLS_HW;
      idx      = '0;
      wr_mask  = '0;
      if (num < L_HW_END) begin
         idx = num;
      end else if (num == L_GRANT) begin
         cls     = CLS_GRANT;
         wr_mask = GRANT_MASK;
      end else if (num < L_SUP_END) begin
         cls     = CLS_SUP;
         idx     = num - L_SUP_BEG;
         wr_mask = SUP_WMASK;
      end else if (num < L_END) begin
         cls     = CLS_USR;
         idx     = num - L_SUP_END;
         wr_mask = USR_WMASK;
      end else begin
         in_range = 1'b0;
      end
   end
endmodule

// File: rtl/sreg_store.sv
module sreg_store
   import sreg_pkg::*;
#(
   parameter int unsigned NUM_W    = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_SUP  = 2,
   parameter int unsigned NUM_USR  = 2,
   parameter logic [DATA_W-1:0] REVISION = '0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               we,
   input  sreg_cls_e          cls,
   input  logic [NUM_W-1:0]   idx,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [DATA_W-1:0]  wmask,
   output logic [DATA_W-1:0]  rdata,
   output logic [NUM_SUP-1:0] grant
);
   localparam int unsigned NUM_REGS = FIRST_SUP + NUM_SUP + NUM_USR;
   localparam logic [DATA_W-1:0] GEOMETRY = DATA_W'({8'(DATA_W), 8'(NUM_REGS)});

   logic [DATA_W-1:0]  sup_q [NUM_SUP];
   logic [DATA_W-1:0]  usr_q [NUM_USR];
   logic [NUM_SUP-1:0] grant_q;

   always_ff @(posedge clk) begin
      if (rst)
         grant_q <= '0;
      else if (we && cls == CLS_GRANT)
         grant_q <= (grant_q & ~wmask[NUM_SUP-1:0]) | (wdata[NUM_SUP-1:0] & wmask[NUM_SUP-1:0]);
   end

   for (genvar k = 0; k < NUM_SUP; k++) begin : g_sup
      always_ff @(posedge clk) begin
         if (rst)
            sup_q[k] <= '0;
         else if (we && cls == CLS_SUP && idx == NUM_W'(k))
            sup_q[k] <= (sup_q[k] & ~wmask) | (wdata & wmask);
      end
   end

   for (genvar k = 0; k < NUM_USR; k++) begin : g_usr
      always_ff @(posedge clk) begin
         if (rst)
            usr_q[k] <= '0;
         else if (we && cls == CLS_USR && idx == NUM_W'(k))
            usr_q[k] <= (usr_q[k] & ~wmask) | (wdata & wmask);
      end
   end

   always_comb begin
      rdata = '0;
      unique case (cls)
         CLS_HW:    rdata = (idx == '0) ? REVISION : GEOMETRY;
         CLS_GRANT: rdata = DATA_W'(grant_q);
         CLS_SUP:   for (int k = 0; k < NUM_SUP; k++) if (idx == NUM_W'(k)) rdata = sup_q[k];
         CLS_USR:   for (int k = 0; k < NUM_USR; k++) if (idx == NUM_W'(k)) rdata = usr_q[k];
         default:   rdata = '0;
      endcase
   end

   assign grant = grant_q;
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
   import sreg_pkg::*;
#(
   parameter int unsigned NUM_W    = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_SUP  = 2,
   parameter int unsigned NUM_USR  = 2,
   parameter logic [DATA_W-1:0] REVISION  = 32'h0000_0A03,
   parameter logic [DATA_W-1:0] SUP_WMASK = 32'h0000_FFFF,
   parameter logic [DATA_W-1:0] USR_WMASK = 32'h00FF_FFFF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic              wr,
   input  logic [NUM_W-1:0]  num,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] wmask,
   input  logic              priv,
   output logic [DATA_W-1:0] rdata,
   output logic              stall,
   output logic              done,
   output logic              trap,
   output logic [1:0]        cause
);
   localparam int unsigned NUM_REGS = FIRST_SUP + NUM_SUP + NUM_USR;

   if (DATA_W < 16) begin : g_chk_width
      $error("DATA_W must hold the geometry word");
   end
   if (NUM_SUP < 1 || NUM_SUP > DATA_W) begin : g_chk_sup
      $error("NUM_SUP out of range");
   end
   if (NUM_REGS >= (1 << NUM_W) || NUM_REGS > 255) begin : g_chk_num
      $error("NUM_W too narrow for the register count");
   end

   logic              pend_q, wr_q, priv_q;
   logic [NUM_W-1:0]  num_q;
   logic [DATA_W-1:0] wdata_q, wmask_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q  <= 1'b0;
         wr_q    <= 1'b0;
         priv_q  <= 1'b0;
         num_q   <= '0;
         wdata_q <= '0;
         wmask_q <= '0;
      end else begin
         pend_q <= req && !pend_q;
         if (req && !pend_q) begin
            wr_q    <= wr;
            priv_q  <= priv;
            num_q   <= num;
            wdata_q <= wdata;
            wmask_q <= wmask;
         end
      end
   end

   logic              in_range;
   sreg_cls_e         cls;
   logic [NUM_W-1:0]  idx;
   logic [DATA_W-1:0] wr_mask, store_rdata;
   logic [NUM_SUP-1:0] grant_v;
   logic              granted, we;
   sreg_cause_e       verdict;

   sreg_decode #(
      .NUM_W(NUM_W), .DATA_W(DATA_W), .NUM_SUP(NUM_SUP), .NUM_USR(NUM_USR),
      .SUP_WMASK(SUP_WMASK), .USR_WMASK(USR_WMASK)
   ) u_decode (
      .num(num_q), .in_range(in_range), .cls(cls), .idx(idx), .wr_mask(wr_mask)
   );

   sreg_store #(
      .NUM_W(NUM_W), .DATA_W(DATA_W), .NUM_SUP(NUM_SUP), .NUM_USR(NUM_USR),
      .REVISION(REVISION)
   ) u_store (
      .clk(clk), .rst(rst), .we(we), .cls(cls), .idx(idx),
      .wdata(wdata_q), .wmask(wmask_q), .rdata(store_rdata), .grant(grant_v)
   );

   always_comb begin
      granted = 1'b0;
      for (int k = 0; k < NUM_SUP; k++)
         if (idx == NUM_W'(k)) granted = grant_v[k];
   end

   always_comb begin
      verdict = CAUSE_NONE;
      if (!in_range) begin
         verdict = CAUSE_RANGE;
      end else if (wr_q) begin
         unique case (cls)
            CLS_HW:    verdict = CAUSE_PRIV;
            CLS_GRANT: if (!priv_q && |(wmask_q & wdata_q)) verdict = CAUSE_PRIV;
            CLS_SUP:   if (!priv_q && !granted) verdict = CAUSE_PRIV;
            default:   verdict = CAUSE_NONE;
         endcase
         if (verdict == CAUSE_NONE && |(wmask_q & ~wr_mask))
            verdict = CAUSE_MASK;
      end
   end

   assign done  = pend_q && verdict == CAUSE_NONE;
   assign trap  = pend_q && verdict != CAUSE_NONE;
   assign cause = trap ? verdict : CAUSE_NONE;
   assign we    = done && wr_q;
   assign rdata = (done && !wr_q) ? store_rdata : '0;
   assign stall = req || pend_q;

   // R9: a verdict is never both accepted and refused
   p_one_verdict_r9: assert property (@(posedge clk) disable iff (rst) !(done && trap));
   // R9: the verdict lasts one cycle and follows a stalled cycle
   p_pulse_single_r9: assert property (@(posedge clk) disable iff (rst)
      (done || trap) |=> !(done || trap));
   p_after_stall_r9: assert property (@(posedge clk) disable iff (rst)
      (done || trap) |-> $past(stall));
   // R8: range trap carries no data
   p_range_zero_r8: assert property (@(posedge clk) disable iff (rst)
      (trap && cause == CAUSE_RANGE) |-> rdata == '0);
   // R5: a grant bit only rises after a privileged accepted access
   p_grant_rise_r5: assert property (@(posedge clk) disable iff (rst)
      (|(grant_v & ~$past(grant_v))) |-> $past(priv_q && done));
endmodule

// File: tb/sreg_bank_test.sv
`timescale 1ns/1ps
module sreg_bank_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req = 1'b0, wr = 1'b0, priv = 1'b0;
   logic [3:0]  num = '0;
   logic [31:0] wdata = '0, wmask = '0;
   logic [31:0] rdata;
   logic        stall, done, trap;
   logic [1:0]  cause;

   always #2 clk = ~clk;

   sreg_bank uut (
      .clk(clk), .rst(rst), .req(req), .wr(wr), .num(num), .wdata(wdata),
      .wmask(wmask), .priv(priv), .rdata(rdata), .stall(stall), .done(done),
      .trap(trap), .cause(cause)
   );

   int checks = 0, fails = 0;
   bit          exp_trap_q [$];
   logic [1:0]  exp_cause_q[$];
   logic [31:0] exp_rd_q   [$];
   string       exp_tag_q  [$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: push the expected verdict, then issue the request
   task automatic access(input bit w, input logic [3:0] n, input logic [31:0] d,
                         input logic [31:0] m, input bit p, input bit et,
                         input logic [1:0] ec, input logic [31:0] er,
                         input string tag, input bit hold = 1'b0);
      @(negedge clk);
      exp_trap_q.push_back(et);
      exp_cause_q.push_back(ec);
      exp_rd_q.push_back(er);
      exp_tag_q.push_back(tag);
      req = 1'b1; wr = w; num = n; wdata = d; wmask = m; priv = p;
      #1 chk("R9 stall in request cycle", 32'(stall), 32'd1);
      @(negedge clk);
      if (hold) begin
         // R9: second request while pending must be ignored
         wr = 1'b1; num = 4'd6; wdata = 32'hFFFF; wmask = 32'hFF; priv = 1'b1;
         #1 chk("R9 stall while pending", 32'(stall), 32'd1);
         @(negedge clk);
      end
      req = 1'b0;
      @(negedge clk);
      chk("R9 stall released", 32'(stall), 32'd0);
   endtask

   // monitor: pop and compare as verdicts appear
   always @(negedge clk) begin
      if (!rst && (done || trap)) begin
         if (exp_trap_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R9 unexpected verdict actual=%0d expected=none", trap);
         end else begin
            string t;
            t = exp_tag_q.pop_front();
            chk({t, " trap"},  32'(trap),  32'(exp_trap_q.pop_front()));
            chk({t, " cause"}, 32'(cause), 32'(exp_cause_q.pop_front()));
            chk({t, " rdata"}, rdata,      exp_rd_q.pop_front());
         end
      end
   end

   task automatic finish_run();
      chk("R9 no missing verdicts", 32'(exp_trap_q.size()), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 stall after reset", 32'(stall), 32'd0);
      chk("R11 done after reset",  32'(done),  32'd0);
      chk("R11 trap after reset",  32'(trap),  32'd0);
      rst = 1'b0;
      // R1 hardwired contents
      access(0, 0, 0, 0, 0, 0, 0, 32'h0000_0A03, "R1 revision");
      access(0, 1, 0, 0, 1, 0, 0, 32'h0000_2007, "R1 geometry");
      // R11 writable registers cleared
      access(0, 3, 0, 0, 0, 0, 0, 0, "R11 sup reset");
      access(0, 6, 0, 0, 0, 0, 0, 0, "R11 usr reset");
      // R2 hardwired write
      access(1, 0, 32'hFFFF, 32'h1, 1, 1, 2, 0, "R2 write hw priv");
      access(1, 1, 32'hFFFF, 32'h1, 0, 1, 2, 0, "R2 write hw user");
      access(0, 0, 0, 0, 1, 0, 0, 32'h0000_0A03, "R2 hw unchanged");
      // R3 supervisor registers
      access(1, 3, 32'h1234, 32'hFFFF, 0, 1, 2, 0, "R3 unpriv write");
      access(0, 3, 0, 0, 0, 0, 0, 0, "R3 unchanged");
      access(1, 3, 32'hABCD, 32'hFFFF, 1, 0, 0, 0, "R3 priv write");
      access(0, 3, 0, 0, 0, 0, 0, 32'hABCD, "R3 readback");
      // R7 masked update
      access(1, 3, 32'h0000_5678, 32'h0000_00F0, 1, 0, 0, 0, "R7 partial write");
      access(0, 3, 0, 0, 0, 0, 0, 32'hAB7D, "R7 readback");
      // R6 mask refusal
      access(1, 3, 32'h0001_0000, 32'h0001_0000, 1, 1, 3, 0, "R6 sup mask");
      access(0, 3, 0, 0, 0, 0, 0, 32'hAB7D, "R6 sup unchanged");
      // R4 user registers
      access(1, 5, 32'h0012_3456, 32'h00FF_FFFF, 0, 0, 0, 0, "R4 user write");
      access(0, 5, 0, 0, 1, 0, 0, 32'h0012_3456, "R4 readback");
      access(1, 5, 32'hFF00_0000, 32'h0100_0000, 0, 1, 3, 0, "R6 usr mask");
      access(0, 5, 0, 0, 0, 0, 0, 32'h0012_3456, "R6 usr unchanged");
      // R8 range
      access(1, 9, 32'h1, 32'h1, 1, 1, 1, 0, "R8 write range");
      access(0, 15, 0, 0, 1, 1, 1, 0, "R8 read range");
      access(0, 7, 0, 0, 0, 1, 1, 0, "R8 first missing");
      // R5 grant handling
      access(1, 2, 32'h1, 32'h1, 0, 1, 2, 0, "R5 unpriv set");
      access(0, 2, 0, 0, 0, 0, 0, 0, "R5 still clear");
      access(1, 2, 32'h1, 32'h1, 1, 0, 0, 0, "R5 priv set");
      access(0, 2, 0, 0, 0, 0, 0, 32'h1, "R5 readback");
      access(1, 3, 32'h1111, 32'hFFFF, 0, 0, 0, 0, "R3 granted write");
      access(0, 3, 0, 0, 0, 0, 0, 32'h1111, "R3 granted readback");
      access(1, 4, 32'h2222, 32'hFFFF, 0, 1, 2, 0, "R3 other still locked");
      // R10 priority: privilege over mask
      access(1, 4, 32'h1_0000, 32'h1_0000, 0, 1, 2, 0, "R10 priv before mask");
      access(1, 2, 32'h0, 32'h1, 0, 0, 0, 0, "R5 unpriv clear");
      access(0, 2, 0, 0, 0, 0, 0, 0, "R5 cleared");
      access(1, 3, 32'h1, 32'h1, 0, 1, 2, 0, "R5 grant revoked");
      // R9 held request is ignored
      access(0, 6, 0, 0, 0, 0, 0, 0, "R9 held read", 1'b1);
      access(0, 6, 0, 0, 0, 0, 0, 0, "R9 second ignored");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule